// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block forms the Montgomery product of two operands, `A * B * 2^(-K) mod n`, for K-bit values (K = `WIDTH`, 128 by default). It avoids any division. It reads the multiplier B one bit per clock, starting from the least significant bit. In each of the K iterations it does three things: it adds A to a running accumulator when the current bit of B is set, it adds the modulus when the running sum is odd, and it shifts the sum right by one. After the last iteration, one conditional subtraction of n brings the value below n.

A caller that performs modular exponentiation issues one product per `start` pulse and waits for the one-cycle `done` strobe. The result stays on `result` until the next completion. Moving values into and out of the Montgomery domain is left to the caller, as are key setup and exponent scanning. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the first accepted `start` must come at least two clock edges after `rst_n` rises.

Top module: `mont_mul`

## Requirements
- R1: When `done` is high, `result` equals `a_in * b_in * 2^(-WIDTH) mod mod_in`, using the operands that were present when `start` was accepted.
- R2: Whenever `done` is high, `result` is fully reduced, that is strictly less than the captured modulus.
- R3: A `start` sampled high while idle is accepted. `done` then rises after the clock edge exactly WIDTH+1 edges later and stays high for exactly one cycle.
- R4: A `start` sampled while an operation is in progress (including its final cycle) is ignored. The captured operands, the result and the timing of the running operation are unaffected.
- R5: While reset is active, and after reset, `done` is 0 and `result` is 0.
- R6: `result` changes only on the cycle in which `done` is high. Otherwise it holds its value, even when the operand inputs change.
- R7: A `start` sampled in the cycle where `done` is high is accepted, so products can run back to back every WIDTH+2 cycles.
- R8: A zero operand (A = 0 or B = 0) gives a result of 0.
- R9: The accumulator is cleared when an operation is accepted. With an odd modulus and operands below it, the accumulator stays below twice the modulus through every iteration, so its WIDTH+2 bits never overflow, including for A = B = n-1 with n = 2^WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a new product; sampled only while idle |
| a_in | input | WIDTH | Multiplicand A, must be below `mod_in` |
| b_in | input | WIDTH | Multiplier B, scanned LSB first, must be below `mod_in` |
| mod_in | input | WIDTH | Modulus n, must be odd |
| result | output | WIDTH | Reduced Montgomery product, held between completions |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bound check on the accumulator and the reduced-result check only hold when the caller supplies an odd modulus and operands strictly below it. The block does not screen its inputs for these conditions. The stimulus therefore forces the low bit of every modulus to one and reduces each random operand modulo that modulus before applying it. The corner operands (zero, n-1 with an all-ones modulus, a minimal modulus) are chosen inside the same limits. The reference model computes the expected product with a full-width multiply, a remainder and K modular halvings. Because it does not use the interleaved serial loop, its result is independent of the datapath it checks.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mont_state_e;
endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic fin,
  output logic busy
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mont_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign fin  = (state_q == ST_FIN);
  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RUN;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RUN: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R3: iteration index never exceeds the operand width
  assert_iter_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q < CW'(WIDTH)));
endmodule

// File: rtl/mont_bshift.sv
module mont_bshift #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] b_in,
  output logic             bit_o
);
  logic [WIDTH-1:0] sr_q, sr_d;
  logic sr_en;

  always_comb begin
    sr_en = load | shift;
    sr_d  = load ? b_in : (sr_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign bit_o = sr_q[0];
endmodule

// File: rtl/mont_step.sv
module mont_step #(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH+1:0] acc_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] n_i,
  input  logic             bit_i,
  output logic [WIDTH+1:0] acc_o
);
  localparam int SW = WIDTH + 3;
  logic [SW-1:0] add_a, add_n, sum1, sum2;

  always_comb begin
    add_a = bit_i ? {3'b000, a_i} : '0;
    sum1  = {1'b0, acc_i} + add_a;
    add_n = sum1[0] ? {3'b000, n_i} : '0;
    sum2  = sum1 + add_n;
    acc_o = sum2[SW-1:1];
  end
endmodule

// File: rtl/mont_final.sv
module mont_final #(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH+1:0] acc_i,
  input  logic [WIDTH-1:0] n_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH+1:0] n_ext, diff;

  always_comb begin
    n_ext = {2'b00, n_i};
    diff  = acc_i - n_ext;
    res_o = (acc_i >= n_ext) ? diff[WIDTH-1:0] : acc_i[WIDTH-1:0];
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] mod_in,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam int AW = WIDTH + 2;

  logic rst_meta_q, rst_sync_n;
  logic load, step, fin, busy, b_bit;
  logic [WIDTH-1:0] a_q, n_q, res_q, res_d;
  logic [AW-1:0] acc_q, acc_d, acc_step;
  logic acc_en, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mont_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .load(load), .step(step), .fin(fin), .busy(busy)
  );

  mont_bshift #(.WIDTH(WIDTH)) u_bshift (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .shift(step),
    .b_in(b_in), .bit_o(b_bit)
  );

  mont_step #(.WIDTH(WIDTH)) u_step (
    .acc_i(acc_q), .a_i(a_q), .n_i(n_q), .bit_i(b_bit), .acc_o(acc_step)
  );

  mont_final #(.WIDTH(WIDTH)) u_final (
    .acc_i(acc_q), .n_i(n_q), .res_o(res_d)
  );

  always_comb begin
    acc_en = load | step;
    acc_d  = load ? '0 : acc_step;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_q    <= '0;
      n_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (load) begin
        a_q <= a_in;
        n_q <= mod_in;
      end
      if (acc_en) acc_q <= acc_d;
      if (fin) res_q <= res_d;
      done_q <= fin;
    end
  end

  assign result = res_q;
  assign done   = done_q;

  // R9: accepted operation starts from a cleared accumulator
  assert_load_clear_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> (acc_q == '0));
  // R9: accumulator stays below 2n during iterations
  assert_acc_bound_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step |-> (acc_q < ({2'b00, n_q} << 1)));
  // R4: captured operands untouched while busy
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> ($stable(a_q) && $stable(n_q)));
  // R3: completion strobe lasts one cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);
  // R2: delivered result is below the modulus
  assert_result_reduced_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> (res_q < n_q));
  // R6: result moves only together with the strobe
  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(res_q) |-> done_q);
endmodule

// File: tb/mont_mul_tb.sv
`timescale 1ns/1ps
module mont_mul_tb;
  localparam int W = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [W-1:0] a, b, n, result;
  logic done;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  logic m_done = 1'b0;
  logic [W-1:0] m_res = '0;
  logic [W-1:0] m_pend = '0;

  always #2.5 clk = ~clk;

  mont_mul #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a), .b_in(b),
    .mod_in(n), .result(result), .done(done)
  );

  function automatic logic [W-1:0] ref_mont(logic [W-1:0] ra, logic [W-1:0] rb,
                                            logic [W-1:0] rn);
    logic [2*W:0] x, ne;
    ne = {{(W+1){1'b0}}, rn};
    x = ({{(W+1){1'b0}}, ra} * {{(W+1){1'b0}}, rb}) % ne;
    for (int i = 0; i < W; i++) x = x[0] ? ((x + ne) >> 1) : (x >> 1);
    return x[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    m_done = 1'b0;
    if (m_cnt == 0 && start) begin
      m_cnt  = W + 1;
      m_pend = ref_mont(a, b, n);
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_done = 1'b1;
        m_res  = m_pend;
      end
    end
    @(posedge clk);
    #1;
    check(done == m_done, "R3 done timing", W'(done), W'(m_done));
    check(result == m_res, "R1 result", result, m_res);
  endtask

  task automatic issue(logic [W-1:0] ia, logic [W-1:0] ib, logic [W-1:0] in);
    a = ia; b = ib; n = in; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!m_done && guard < 1000) begin
      tick();
      guard++;
    end
    if (guard >= 1000) check(1'b0, "R3 no completion", '0, '1);
  endtask

  task automatic run_op(logic [W-1:0] ia, logic [W-1:0] ib, logic [W-1:0] in, string req);
    logic [W-1:0] exp;
    exp = ref_mont(ia, ib, in);
    issue(ia, ib, in);
    wait_done();
    check(result == exp, req, result, exp);
    check(result < in, "R2 reduced", result, in);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb, rn, e1, e2, held;
    rst_n = 1'b0; start = 1'b0; a = '0; b = '0; n = 'd1;
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b0, "R5 done in reset", W'(done), '0);
    check(result == '0, "R5 result in reset", result, '0);
    rst_n = 1'b1;
    repeat (3) tick();
    check(done == 1'b0 && result == '0, "R5 after reset", result, '0);

    // R1/R2: random operands
    for (int t = 0; t < 6; t++) begin
      rn = rnd() | 1 | (W'(1) << (W - 1));
      ra = rnd() % rn;
      rb = rnd() % rn;
      run_op(ra, rb, rn, "R1 random product");
    end
    // R1: small modulus
    run_op('d5, 'd9, 'd13, "R1 small modulus");
    // R8: zero operands
    rn = rnd() | 1;
    run_op('0, rnd() % rn, rn, "R8 zero A");
    run_op(rnd() % rn, '0, rn, "R8 zero B");
    check(result == '0, "R8 zero result", result, '0);
    // R9: maximal operands with all-ones modulus
    rn = '1;
    run_op(rn - 1, rn - 1, rn, "R9 max operands");

    // R4: start while busy is ignored
    rn = rnd() | 1; ra = rnd() % rn; rb = rnd() % rn;
    e1 = ref_mont(ra, rb, rn);
    issue(ra, rb, rn);
    repeat (5) tick();
    a = rnd() % rn; b = rnd() % rn; start = 1'b1;
    repeat (3) tick();
    start = 1'b0;
    wait_done();
    check(result == e1, "R4 busy start ignored", result, e1);

    // R7: start in the done cycle is accepted
    rn = rnd() | 1; ra = rnd() % rn; rb = rnd() % rn;
    e1 = ref_mont(ra, rb, rn);
    issue(ra, rb, rn);
    wait_done();
    check(result == e1, "R7 first product", result, e1);
    ra = rnd() % rn; rb = rnd() % rn;
    e2 = ref_mont(ra, rb, rn);
    issue(ra, rb, rn);
    check(m_cnt == W + 1, "R7 accepted in done cycle", W'(m_cnt), W'(W + 1));
    wait_done();
    check(result == e2, "R7 back to back", result, e2);

    // R6: result held while inputs move
    held = result;
    for (int t = 0; t < 10; t++) begin
      a = rnd(); b = rnd();
      tick();
    end
    check(result == held, "R6 result held", result, held);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule